// File: doc/BRIEF.md
# Display Line-Buffer Refill Request Decoder

This block sits in front of a display controller's line buffer and decides when that buffer may ask shared memory for another four-word burst. A 16-entry word FIFO is addressed by a 4-bit write counter and a 4-bit read counter. A fixed boolean function of the two counters produces the refill request. The request fires only when both counters sit on a four-word group boundary, and only while the writer is 0, 4 or 8 entries ahead of the reader. The request is registered once before it leaves the block, and a parameter selects whether it is asserted high or low.

The memory side answers each granted request by presenting four words on consecutive fill strobes. The display side takes one word per pop strobe. The counters and the storage are included so that the request can be judged against real fill levels: when the FIFO is already twelve entries ahead, it discards any further incoming word, so it can never overflow.

Top module: `dfr_disp_fifo`

## Requirements
- R1: Each counter is 4 bits wide. Each accepted fill word advances the write counter by one, and each accepted pop advances the read counter by one, both wrapping from 15 to 0. Words come out in the order they were written, across the wrap.
- R2: The raw request is true exactly for these pairs of (read counter, write counter): read 0 with write 0, 4 or 8; read 4 with write 4, 8 or 12; read 8 with write 8, 12 or 0; read 12 with write 12, 0 or 4. For all other pairs it is false.
- R3: The request output is registered. In any cycle it shows the decode of the counter values that held before the most recent rising clock edge.
- R4: With REQ_POL = REQ_ACT_HIGH, an asserted request drives mem_req to 1. With REQ_POL = REQ_ACT_LOW, an asserted request drives it to 0 and a deasserted request drives it to 1.
- R5: An accepted pop places the head word on pix_data and sets pix_valid to 1 on the next clock edge. In cycles without an accepted pop, pix_valid is 0 and pix_data holds its last value.
- R6: A fill word that arrives while the write counter is 12 entries ahead of the read counter is discarded. The write counter does not move, and the word never appears at the output.
- R7: A pop while the FIFO is empty (counters equal) is ignored: pix_valid stays 0 and the read counter does not move.
- R8: While rst_n is low, both counters are 0, the FIFO is empty, pix_valid and pix_data are 0, and mem_req is at its deasserted level.
- R9: A fill and a pop in the same cycle both take effect when each is individually allowed by the occupancy before that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_req | output | 1 | Registered refill request to the memory arbiter, polarity set by REQ_POL |
| fill_valid | input | 1 | One word from memory is present on fill_data this cycle |
| fill_data | input | DATA_W | Word returned by memory |
| pix_pop | input | 1 | Display side takes one word this cycle |
| pix_data | output | DATA_W | Word popped in the previous cycle |
| pix_valid | output | 1 | pix_data was updated by a pop on the last edge |

## Verification
The assertions assume that fill_valid, fill_data and pix_pop are stable around the rising edge and free of X once reset is released. They also assume that the memory side never needs more than four words per request, so the discard rule is the only overflow guard. The bench drives every input on the falling edge and samples on the next falling edge. Its memory responder pushes exactly four words per burst, except in the one scenario that pushes a word into a FIFO that is twelve entries ahead on purpose. The pop stimulus deliberately includes pops on an empty FIFO and pops that land off a group boundary, so the decode is exercised for unaligned counters as well as aligned ones.

// File: rtl/dfr_pkg.sv
`timescale 1ns/1ps
package dfr_pkg;

    // Level that mem_req takes when a refill is requested
    typedef enum logic {
        REQ_ACT_LOW  = 1'b0,
        REQ_ACT_HIGH = 1'b1
    } req_pol_e;

endpackage

// File: rtl/dfr_ptr_ctrl.sv
`timescale 1ns/1ps
module dfr_ptr_ctrl #(
    parameter int PTR_W = 4,
    parameter int BURST = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    output logic [PTR_W-1:0] wr_ptr_o,
    output logic [PTR_W-1:0] rd_ptr_o,
    output logic             push_ok_o,
    output logic             pop_ok_o
);
    localparam int DEPTH    = 1 << PTR_W;
    localparam int FILL_MAX = DEPTH - BURST;
    localparam logic [PTR_W-1:0] FILL_LIM = PTR_W'(FILL_MAX);
    localparam logic [PTR_W-1:0] ONE      = PTR_W'(1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
    } ptr_s;

    ptr_s             st_d, st_q;
    logic [PTR_W-1:0] level;
    logic             push_ok, pop_ok;

    always_comb begin
        level   = st_q.wr - st_q.rd;
        push_ok = push_i && (level < FILL_LIM);
        pop_ok  = pop_i && (level != '0);
        st_d    = st_q;
        if (push_ok) st_d.wr = st_q.wr + ONE;
        if (pop_ok)  st_d.rd = st_q.rd + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_ptr_o  = st_q.wr;
    assign rd_ptr_o  = st_q.rd;
    assign push_ok_o = push_ok;
    assign pop_ok_o  = pop_ok;

    // R6: occupancy never exceeds the discard threshold
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (level <= FILL_LIM));

    // R1: the read counter moves by at most one step per cycle
    assert_rd_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rd == $past(st_q.rd)) || (st_q.rd == $past(st_q.rd) + ONE));

    // R7: a pop on an empty FIFO leaves the read counter alone
    assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && (level == '0)) |=> (st_q.rd == $past(st_q.rd)));

endmodule

// File: rtl/dfr_word_store.sv
`timescale 1ns/1ps
module dfr_word_store #(
    parameter int DATA_W = 16,
    parameter int PTR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [PTR_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic [PTR_W-1:0]  rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o
);
    localparam int DEPTH = 1 << PTR_W;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } out_s;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];
    out_s              out_d, out_q;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en_i) mem_d[wr_idx_i] = wr_data_i;
        out_d.valid = rd_en_i;
        out_d.data  = rd_en_i ? mem_q[rd_idx_i] : out_q.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
            out_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
            out_q <= out_d;
        end
    end

    assign rd_data_o  = out_q.data;
    assign rd_valid_o = out_q.valid;

    // R9: a same-cycle write and read never target the same slot
    assert_no_slot_clash_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && rd_en_i && (wr_idx_i == rd_idx_i)));

endmodule

// File: rtl/dfr_req_decode.sv
`timescale 1ns/1ps
module dfr_req_decode #(
    parameter int PTR_W = 4,
    parameter int BURST = 4
) (
    input  logic [PTR_W-1:0] wr_ptr_i,
    input  logic [PTR_W-1:0] rd_ptr_i,
    output logic             req_o
);
    localparam int GRP_BITS  = $clog2(BURST);
    localparam int MAX_AHEAD = (1 << PTR_W) - 2 * BURST;
    localparam logic [PTR_W-1:0] AHEAD_LIM = PTR_W'(MAX_AHEAD);

    logic [PTR_W-1:0] ahead;
    logic             wr_grp, rd_grp;

    always_comb begin
        ahead  = wr_ptr_i - rd_ptr_i;
        wr_grp = (wr_ptr_i[GRP_BITS-1:0] == '0);
        rd_grp = (rd_ptr_i[GRP_BITS-1:0] == '0);
        req_o  = wr_grp && rd_grp && (ahead <= AHEAD_LIM);
    end

endmodule

// File: rtl/dfr_disp_fifo.sv
`timescale 1ns/1ps
module dfr_disp_fifo
    import dfr_pkg::*;
#(
    parameter int       DATA_W  = 16,
    parameter int       PTR_W   = 4,
    parameter int       BURST   = 4,
    parameter req_pol_e REQ_POL = REQ_ACT_HIGH
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_req,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              pix_pop,
    output logic [DATA_W-1:0] pix_data,
    output logic              pix_valid
);
    localparam int GRP_BITS = $clog2(BURST);

    typedef struct packed {
        logic req;
    } top_s;

    top_s             st_d, st_q;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             push_ok, pop_ok, req_raw;

    dfr_ptr_ctrl #(.PTR_W(PTR_W), .BURST(BURST)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (fill_valid),
        .pop_i     (pix_pop),
        .wr_ptr_o  (wr_ptr),
        .rd_ptr_o  (rd_ptr),
        .push_ok_o (push_ok),
        .pop_ok_o  (pop_ok)
    );

    dfr_word_store #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (push_ok),
        .wr_idx_i   (wr_ptr),
        .wr_data_i  (fill_data),
        .rd_en_i    (pop_ok),
        .rd_idx_i   (rd_ptr),
        .rd_data_o  (pix_data),
        .rd_valid_o (pix_valid)
    );

    dfr_req_decode #(.PTR_W(PTR_W), .BURST(BURST)) u_dec (
        .wr_ptr_i (wr_ptr),
        .rd_ptr_i (rd_ptr),
        .req_o    (req_raw)
    );

    always_comb begin
        st_d     = st_q;
        st_d.req = req_raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        if (REQ_POL == REQ_ACT_HIGH) begin : g_pol_high
            assign mem_req = st_q.req;
        end else begin : g_pol_low
            assign mem_req = ~st_q.req;
        end
    endgenerate

    // R2: a registered request only follows group-aligned counters
    assert_req_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.req |-> (($past(wr_ptr[GRP_BITS-1:0]) == '0) &&
                      ($past(rd_ptr[GRP_BITS-1:0]) == '0)));

endmodule

// File: tb/test_dfr_disp_fifo.sv
`timescale 1ns/1ps
module test_dfr_disp_fifo;
    import dfr_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fill_valid = 1'b0;
    logic [15:0] fill_data = '0;
    logic        pix_pop = 1'b0;
    logic        mem_req, mem_req_n;
    logic [15:0] pix_data, pix_data_n;
    logic        pix_valid, pix_valid_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [3:0]  m_wr = '0;
    logic [3:0]  m_rd = '0;
    logic [15:0] m_mem [16];
    logic [15:0] m_last = '0;
    logic [15:0] nxt_word = 16'hA000;

    always #4 clk = ~clk;

    dfr_disp_fifo #(.DATA_W(16), .PTR_W(4), .BURST(4), .REQ_POL(REQ_ACT_HIGH)) i_dfr_disp_fifo (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req),
        .fill_valid(fill_valid), .fill_data(fill_data),
        .pix_pop(pix_pop), .pix_data(pix_data), .pix_valid(pix_valid)
    );

    dfr_disp_fifo #(.DATA_W(16), .PTR_W(4), .BURST(4), .REQ_POL(REQ_ACT_LOW)) i_dfr_disp_fifo_low (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req_n),
        .fill_valid(fill_valid), .fill_data(fill_data),
        .pix_pop(pix_pop), .pix_data(pix_data_n), .pix_valid(pix_valid_n)
    );

    function automatic bit req_tab(input logic [3:0] rd, input logic [3:0] wr);
        case (rd)
            4'd0:    return (wr == 4'd0)  || (wr == 4'd4)  || (wr == 4'd8);
            4'd4:    return (wr == 4'd4)  || (wr == 4'd8)  || (wr == 4'd12);
            4'd8:    return (wr == 4'd8)  || (wr == 4'd12) || (wr == 4'd0);
            4'd12:   return (wr == 4'd12) || (wr == 4'd0)  || (wr == 4'd4);
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one clock cycle of stimulus, checked on the following falling edge
    task automatic cycle(input bit push, input logic [15:0] d, input bit pop);
        logic [3:0]  lvl;
        logic [15:0] exp_data;
        bit          exp_req, p_ok, q_ok;
        lvl      = m_wr - m_rd;
        exp_req  = req_tab(m_rd, m_wr);
        p_ok     = push && (lvl < 4'd12);
        q_ok     = pop && (lvl != 4'd0);
        exp_data = q_ok ? m_mem[m_rd] : m_last;
        if (p_ok) begin m_mem[m_wr] = d; m_wr = m_wr + 4'd1; end
        if (q_ok) m_rd = m_rd + 4'd1;
        m_last     = exp_data;
        fill_valid = push;
        fill_data  = d;
        pix_pop    = pop;
        @(posedge clk);
        @(negedge clk);
        fill_valid = 1'b0;
        pix_pop    = 1'b0;
        chk(mem_req == exp_req, "R2 R3 request", {31'b0, mem_req}, {31'b0, exp_req});
        chk(mem_req_n == !exp_req, "R4 low polarity", {31'b0, mem_req_n}, {31'b0, !exp_req});
        chk(pix_valid == q_ok, "R5 R7 pix_valid", {31'b0, pix_valid}, {31'b0, q_ok});
        chk(pix_data == exp_data, "R5 R1 pix_data", {16'b0, pix_data}, {16'b0, exp_data});
    endtask

    task automatic burst();
        for (int k = 0; k < 4; k++) begin
            cycle(1'b1, nxt_word, 1'b0);
            nxt_word = nxt_word + 16'd1;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(mem_req == 1'b0, "R8 reset req high-pol", {31'b0, mem_req}, 32'd0);
        chk(mem_req_n == 1'b1, "R8 R4 reset req low-pol", {31'b0, mem_req_n}, 32'd1);
        chk(pix_valid == 1'b0, "R8 reset pix_valid", {31'b0, pix_valid}, 32'd0);
        chk(pix_data == 16'd0, "R8 reset pix_data", {16'b0, pix_data}, 32'd0);
        rst_n = 1'b1;
        cycle(1'b0, '0, 1'b0);
        chk(mem_req == 1'b1, "R8 R2 empty fifo requests", {31'b0, mem_req}, 32'd1);
    endtask

    task automatic t_burst_on_request();
        burst();
        cycle(1'b0, '0, 1'b0);
        chk(mem_req == 1'b1, "R2 four ahead requests", {31'b0, mem_req}, 32'd1);
        burst();
        burst();
        cycle(1'b0, '0, 1'b0);
        chk(mem_req == 1'b0, "R2 twelve ahead no request", {31'b0, mem_req}, 32'd0);
    endtask

    task automatic t_discard_when_full();
        cycle(1'b1, 16'hDEAD, 1'b0);   // R6: dropped word
        cycle(1'b0, '0, 1'b0);
        for (int k = 0; k < 12; k++) cycle(1'b0, '0, 1'b1);
        cycle(1'b0, '0, 1'b1);         // R7: empty pop
        chk(pix_valid == 1'b0, "R6 R7 no thirteenth word", {31'b0, pix_valid}, 32'd0);
        chk(pix_data != 16'hDEAD, "R6 dropped word absent", {16'b0, pix_data}, 32'd0);
    endtask

    task automatic t_misaligned_read();
        burst();
        burst();
        cycle(1'b0, '0, 1'b1);         // read counter leaves its group
        cycle(1'b0, '0, 1'b0);
        chk(mem_req == 1'b0, "R2 unaligned read no request", {31'b0, mem_req}, 32'd0);
        for (int k = 0; k < 3; k++) cycle(1'b0, '0, 1'b1);
        cycle(1'b0, '0, 1'b0);
        chk(mem_req == 1'b1, "R2 realigned read requests", {31'b0, mem_req}, 32'd1);
    endtask

    task automatic t_push_pop_same_cycle();
        for (int k = 0; k < 6; k++) begin
            cycle(1'b1, nxt_word, 1'b1);   // R9
            nxt_word = nxt_word + 16'd1;
        end
        while (m_wr != m_rd) cycle(1'b0, '0, 1'b1);
        cycle(1'b0, '0, 1'b0);
    endtask

    task automatic t_wrap();
        for (int r = 0; r < 6; r++) begin  // R1: counters wrap several times
            burst();
            cycle(1'b0, '0, 1'b1);
            cycle(1'b0, '0, 1'b1);
            burst();
            for (int k = 0; k < 6; k++) cycle(1'b0, '0, 1'b1);
        end
        cycle(1'b0, '0, 1'b0);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) m_mem[i] = '0;
        @(negedge clk);
        t_reset();
        t_burst_on_request();
        t_discard_when_full();
        t_misaligned_read();
        t_push_pop_same_cycle();
        t_wrap();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule